// File: doc/BRIEF.md
# Two-Bin Conditional-Context Arithmetic Decoder

This block takes an arithmetic-coded bit stream and recovers up to two binary decisions per clock. The second decision's context normally depends on the value of the first. So the caller supplies three probabilities: one for the first bin, and one second-bin probability for each possible value of the first bin. The block turns them into four joint sub-intervals, places the offset among them with parallel comparisons, and reports both bins at once. It then narrows the interval, renormalizes once, and refills the offset from the stream.

A step can run in one of three modes. The one-bin mode matches a serial decoder. The two-bin mode resolves a pair. The padded mode decodes a filler second bin at a fixed skewed probability and drops it. With these modes the decoder can follow an encoder that switches rate between groups of decisions, and can absorb the filler bin that closes a group of odd length. Stream words go into a small bit buffer. Decode requests stall through a ready signal whenever the buffer cannot cover a worst-case renormalization.

Top module: `bin2_arith_dec`

## Requirements
- R1: After reset, out_valid_o is 0, dec_ready_o is 0 and in_ready_o is 1. The first 14 stream bits are loaded into the offset before any decode is accepted. The range starts at 16383.
- R2: dec_ready_o is 1 only once the offset is loaded and at least 12 unconsumed stream bits are buffered. A request made while it is 0 changes neither the outputs nor the range/offset state.
- R3: In mode_i=1 (pair), the range R is split, from low to high, into sub-intervals for the pairs 00, 01, 10 and 11. With q=R>>6, the first three sizes are (q·a·b)>>6, (q·a·(64−b))>>6 and (q·(64−a)·c)>>6, and the last one takes what remains. The sub-interval holding the offset gives bin_first_o and bin_second_o.
- R4: Each 6-bit probability is the chance of a 0, in units of 1/64. a comes from prob_a_i, and b or c (prob_b_i or prob_c_i) is used for the second bin when the first bin is 0 or 1. A value of 0 is treated as 1.
- R5: In mode_i=0 (and mode_i=3), one bin is decoded against the boundary q·a. The bin is 0 when the offset is below the boundary. out_cnt_o is 1.
- R6: In mode_i=2 (padded), a pair is decoded with b=c=1. The second bin is discarded: out_cnt_o is 1 and bin_second_o is 0.
- R7: After a decode, the range becomes the selected size and the offset drops by that sub-interval's low edge. Both are then shifted left together, once per step, until the range is at least 4096. Each shift brings the next stream bit into the offset.
- R8: The outputs are registered. out_valid_o is 1 for exactly the cycle after an accepted request, out_cnt_o is 2 in pair mode, and bin_first_o carries the earlier bin.
- R9: in_ready_o is 1 while at most 16 unconsumed bits are buffered. A 16-bit word is taken when in_valid_i and in_ready_o are both 1, and its MSB comes first in the stream.
- R10: The buffer never holds more than 32 bits, never gives out more bits than it holds, and the offset stays below the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 16 | Stream word, MSB first |
| in_valid_i | input | 1 | Stream word valid |
| in_ready_o | output | 1 | Buffer can take a word |
| dec_valid_i | input | 1 | Decode request |
| dec_ready_o | output | 1 | Decode request can be taken |
| mode_i | input | 2 | 0 one-bin, 1 pair, 2 padded, 3 one-bin |
| prob_a_i | input | 6 | First-bin probability of 0 |
| prob_b_i | input | 6 | Second-bin probability of 0 if first bin is 0 |
| prob_c_i | input | 6 | Second-bin probability of 0 if first bin is 1 |
| out_valid_o | output | 1 | Decoded result valid |
| out_cnt_o | output | 2 | Number of delivered bins (1 or 2) |
| bin_first_o | output | 1 | First decoded bin |
| bin_second_o | output | 1 | Second decoded bin (0 when count is 1) |

## Verification
A table of probability sets is replayed over a pseudo-random stream. It mixes balanced, extreme (1 and 63) and asymmetric second-bin candidates, so every one of the four sub-intervals is hit, including the tiny ones that force long renormalizations. A wrong boundary or a swapped b/c shows up as a diverging bin sequence, and because each step feeds the next, an error in a range or offset update shows up in later bins too. The stream is fed at full rate on some passes and throttled on others, and it is stopped outright in one phase. This separates correct stalling from decoding with missing bits. Zero probabilities, the alternate one-bin code and padded steps check the corner encodings.

// File: rtl/bin2_pkg.sv
package bin2_pkg;
  typedef enum logic [1:0] {
    MODE_ONE     = 2'd0,
    MODE_TWO     = 2'd1,
    MODE_PAD     = 2'd2,
    MODE_ONE_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/bin2_bitbuf.sv
module bin2_bitbuf #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned BUF_W  = 32,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned HEAD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CNT_W-1:0]  take_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [HEAD_W-1:0] head_o
);
  localparam int unsigned PAD_W = BUF_W - IN_W;

  logic [BUF_W-1:0] bits_q, bits_d, ext;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_rem;
  logic             push;

  assign in_ready_o = cnt_q <= CNT_W'(PAD_W);
  assign push       = in_valid_i && in_ready_o;
  assign ext        = {in_data_i, {PAD_W{1'b0}}};
  assign cnt_rem    = cnt_q - take_i;

  // bits beyond cnt are always zero, so a new word can be OR-ed in
  always_comb begin
    bits_d = bits_q << take_i;
    cnt_d  = cnt_rem;
    if (push) begin
      bits_d = bits_d | (ext >> cnt_rem);
      cnt_d  = cnt_rem + CNT_W'(IN_W);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign head_o = bits_q[BUF_W-1 -: HEAD_W];

  AST_BUF_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_W)); // R10
  AST_TAKE_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i <= cnt_q); // R10
endmodule

// File: rtl/bin2_interval.sv
module bin2_interval
  import bin2_pkg::*;
#(
  parameter int unsigned RANGE_W = 14,
  parameter int unsigned PROB_W  = 6
) (
  input  logic [RANGE_W-1:0] range_i,
  input  logic [RANGE_W-1:0] offset_i,
  input  logic [1:0]         mode_i,
  input  logic [PROB_W-1:0]  pa_i,
  input  logic [PROB_W-1:0]  pb_i,
  input  logic [PROB_W-1:0]  pc_i,
  output logic               bin_a_o,
  output logic               bin_b_o,
  output logic               pair_o,
  output logic [RANGE_W-1:0] sub_range_o,
  output logic [RANGE_W-1:0] sub_low_o
);
  localparam int unsigned RQ_W = RANGE_W - PROB_W;
  localparam int unsigned W_W  = 2 * PROB_W + 2;
  localparam int unsigned PR_W = RQ_W + W_W;
  localparam logic [PROB_W:0] ONE_V = {1'b1, {PROB_W{1'b0}}};
  localparam logic [PROB_W:0] MIN_V = (PROB_W+1)'(1);

  mode_e              mode;
  logic               two_path;
  logic [RQ_W-1:0]    rq;
  logic [PROB_W:0]    pa, pb, pc;
  logic [W_W-1:0]     wt [3];
  logic [RANGE_W-1:0] part [3];
  logic [RANGE_W-1:0] c1, c2, c3, s3, cs;
  logic               ge1, ge2, ge3, ges;

  assign mode     = mode_e'(mode_i);
  assign two_path = (mode == MODE_TWO) || (mode == MODE_PAD);
  assign rq       = range_i[RANGE_W-1:PROB_W];

  assign pa = (pa_i == '0) ? MIN_V : {1'b0, pa_i};
  assign pb = (mode == MODE_PAD || pb_i == '0) ? MIN_V : {1'b0, pb_i};
  assign pc = (mode == MODE_PAD || pc_i == '0) ? MIN_V : {1'b0, pc_i};

  // joint weights of the three lower sub-intervals, 1/4096 units
  assign wt[0] = W_W'(pa) * W_W'(pb);
  assign wt[1] = W_W'(pa) * W_W'(ONE_V - pb);
  assign wt[2] = W_W'(ONE_V - pa) * W_W'(pc);

  for (genvar g = 0; g < 3; g++) begin : g_part
    logic [PR_W-1:0] prod;
    assign prod    = PR_W'(rq) * PR_W'(wt[g]);
    assign part[g] = RANGE_W'(prod >> PROB_W);
  end

  assign c1 = part[0];
  assign c2 = c1 + part[1];
  assign c3 = c2 + part[2];
  assign s3 = range_i - c3;
  assign cs = RANGE_W'(rq) * RANGE_W'(pa);

  // boundary comparisons run side by side
  assign ge1 = offset_i >= c1;
  assign ge2 = offset_i >= c2;
  assign ge3 = offset_i >= c3;
  assign ges = offset_i >= cs;

  always_comb begin
    pair_o = (mode == MODE_TWO);
    if (two_path) begin
      if (ge3) begin
        bin_a_o = 1'b1; bin_b_o = 1'b1; sub_low_o = c3; sub_range_o = s3;
      end else if (ge2) begin
        bin_a_o = 1'b1; bin_b_o = 1'b0; sub_low_o = c2; sub_range_o = part[2];
      end else if (ge1) begin
        bin_a_o = 1'b0; bin_b_o = 1'b1; sub_low_o = c1; sub_range_o = part[1];
      end else begin
        bin_a_o = 1'b0; bin_b_o = 1'b0; sub_low_o = '0; sub_range_o = part[0];
      end
    end else begin
      bin_b_o = 1'b0;
      if (ges) begin
        bin_a_o = 1'b1; sub_low_o = cs; sub_range_o = range_i - cs;
      end else begin
        bin_a_o = 1'b0; sub_low_o = '0; sub_range_o = cs;
      end
    end
  end
endmodule

// File: rtl/bin2_renorm.sv
module bin2_renorm #(
  parameter int unsigned RANGE_W = 14,
  parameter int unsigned SH_W    = 4
) (
  input  logic [RANGE_W-1:0]   range_i,
  input  logic [RANGE_W-1:0]   offset_i,
  input  logic [RANGE_W-3:0]   fill_i,
  output logic [RANGE_W-1:0]   range_o,
  output logic [RANGE_W-1:0]   offset_o,
  output logic [SH_W-1:0]      shift_o
);
  localparam int unsigned MAX_SHIFT = RANGE_W - 2;
  localparam logic [SH_W-1:0] MAX_SH_V = SH_W'(MAX_SHIFT);

  always_comb begin
    shift_o = '0;
    for (int i = 0; i < RANGE_W; i++) begin
      if (range_i[i]) shift_o = (i >= int'(MAX_SHIFT)) ? '0 : SH_W'(int'(MAX_SHIFT) - i);
    end
  end

  assign range_o  = range_i << shift_o;
  assign offset_o = (offset_i << shift_o) | RANGE_W'(fill_i >> (MAX_SH_V - shift_o));
endmodule

// File: rtl/bin2_arith_dec.sv
module bin2_arith_dec
  import bin2_pkg::*;
#(
  parameter int unsigned RANGE_W = 14,
  parameter int unsigned PROB_W  = 6,
  parameter int unsigned IN_W    = 16,
  parameter int unsigned BUF_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              dec_valid_i,
  output logic              dec_ready_o,
  input  logic [1:0]        mode_i,
  input  logic [PROB_W-1:0] prob_a_i,
  input  logic [PROB_W-1:0] prob_b_i,
  input  logic [PROB_W-1:0] prob_c_i,
  output logic              out_valid_o,
  output logic [1:0]        out_cnt_o,
  output logic              bin_first_o,
  output logic              bin_second_o
);
  localparam int unsigned MAX_SHIFT = RANGE_W - 2;
  localparam int unsigned CNT_W     = $clog2(BUF_W + 1);
  localparam int unsigned SH_W      = $clog2(MAX_SHIFT + 1);
  localparam logic [RANGE_W-1:0] MIN_RANGE = RANGE_W'(1) << MAX_SHIFT;

  logic               init_q, fire, load;
  logic [RANGE_W-1:0] range_q, offset_q;
  logic [CNT_W-1:0]   cnt, take;
  logic [RANGE_W-1:0] head;
  logic               bin_a, bin_b, pair;
  logic [RANGE_W-1:0] sub_range, sub_low, ren_range, ren_off;
  logic [SH_W-1:0]    shift;

  bin2_bitbuf #(.IN_W(IN_W), .BUF_W(BUF_W), .CNT_W(CNT_W), .HEAD_W(RANGE_W)) u_buf (
    .clk_i, .rst_ni, .in_data_i, .in_valid_i, .in_ready_o,
    .take_i(take), .cnt_o(cnt), .head_o(head)
  );

  bin2_interval #(.RANGE_W(RANGE_W), .PROB_W(PROB_W)) u_iv (
    .range_i(range_q), .offset_i(offset_q), .mode_i,
    .pa_i(prob_a_i), .pb_i(prob_b_i), .pc_i(prob_c_i),
    .bin_a_o(bin_a), .bin_b_o(bin_b), .pair_o(pair),
    .sub_range_o(sub_range), .sub_low_o(sub_low)
  );

  bin2_renorm #(.RANGE_W(RANGE_W), .SH_W(SH_W)) u_rn (
    .range_i(sub_range), .offset_i(offset_q - sub_low),
    .fill_i(head[RANGE_W-1 -: MAX_SHIFT]),
    .range_o(ren_range), .offset_o(ren_off), .shift_o(shift)
  );

  assign dec_ready_o = init_q && (cnt >= CNT_W'(MAX_SHIFT));
  assign fire        = dec_valid_i && dec_ready_o;
  assign load        = !init_q && (cnt >= CNT_W'(RANGE_W));
  assign take        = load ? CNT_W'(RANGE_W) : (fire ? CNT_W'(shift) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b0;
      range_q  <= '1;
      offset_q <= '0;
    end else if (load) begin
      init_q   <= 1'b1;
      range_q  <= '1;
      offset_q <= head;
    end else if (fire) begin
      range_q  <= ren_range;
      offset_q <= ren_off;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_cnt_o    <= '0;
      bin_first_o  <= 1'b0;
      bin_second_o <= 1'b0;
    end else begin
      out_valid_o <= fire;
      if (fire) begin
        out_cnt_o    <= pair ? 2'd2 : 2'd1;
        bin_first_o  <= bin_a;
        bin_second_o <= pair & bin_b;
      end
    end
  end

  AST_RANGE_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> range_q >= MIN_RANGE); // R7
  AST_OFFSET_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> offset_q < range_q); // R10
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !fire) |=> ($stable(range_q) && $stable(offset_q) && !out_valid_o)); // R2
  AST_PAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_e'(mode_i) == MODE_PAD) |=> (out_cnt_o == 2'd1 && !bin_second_o)); // R6
  AST_OUT_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_o == 2'd1 || out_cnt_o == 2'd2)); // R8
endmodule

// File: tb/tb_bin2_arith_dec.sv
`timescale 1ns/1ps
module tb_bin2_arith_dec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        dec_valid_i = 1'b0;
  logic        dec_ready_o;
  logic [1:0]  mode_i = '0;
  logic [5:0]  prob_a_i = '0, prob_b_i = '0, prob_c_i = '0;
  logic        out_valid_o;
  logic [1:0]  out_cnt_o;
  logic        bin_first_o, bin_second_o;

  bin2_arith_dec dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int mr = 0, mv = 0, consumed = 0, fed = 0;
  bit init_m = 0;

  // {mode, pa, pb, pc}
  localparam logic [19:0] TBL [16] = '{
    {2'd1, 6'd32, 6'd32, 6'd32}, {2'd1, 6'd63, 6'd63, 6'd1},
    {2'd0, 6'd40, 6'd0,  6'd0 }, {2'd1, 6'd1,  6'd63, 6'd63},
    {2'd2, 6'd50, 6'd0,  6'd0 }, {2'd1, 6'd20, 6'd45, 6'd10},
    {2'd0, 6'd1,  6'd0,  6'd0 }, {2'd1, 6'd0,  6'd30, 6'd0 },
    {2'd3, 6'd63, 6'd0,  6'd0 }, {2'd1, 6'd48, 6'd8,  6'd56},
    {2'd2, 6'd5,  6'd0,  6'd0 }, {2'd1, 6'd32, 6'd1,  6'd63},
    {2'd0, 6'd63, 6'd0,  6'd0 }, {2'd1, 6'd60, 6'd60, 6'd60},
    {2'd2, 6'd32, 6'd0,  6'd0 }, {2'd1, 6'd7,  6'd33, 6'd19}
  };

  function automatic logic [15:0] word_f(int i);
    logic [31:0] x;
    x = 32'(i) * 32'h9E37_79B1 + 32'h7F4A_7C15;
    x = x ^ (x >> 15);
    if (i == 0) x[15] = 1'b0;
    return x[15:0];
  endfunction

  function automatic bit sbit(int k);
    logic [15:0] w;
    w = word_f(k / 16);
    return w[15 - (k % 16)];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference step from the requirements: returns bins and count
  task automatic model_dec(input int md, input int pa, input int pb, input int pc,
                           output int e0, output int e1, output int ec);
    int q, a, b, c, s, low, c1, c2, c3;
    q = mr / 64;
    a = (pa == 0) ? 1 : pa;
    b = (md == 2 || pb == 0) ? 1 : pb;
    c = (md == 2 || pc == 0) ? 1 : pc;
    e1 = 0;
    if (md == 1 || md == 2) begin
      c1 = (q * a * b) / 64;
      c2 = c1 + (q * a * (64 - b)) / 64;
      c3 = c2 + (q * (64 - a) * c) / 64;
      if (mv >= c3)      begin e0 = 1; e1 = 1; low = c3; s = mr - c3; end
      else if (mv >= c2) begin e0 = 1; e1 = 0; low = c2; s = c3 - c2; end
      else if (mv >= c1) begin e0 = 0; e1 = 1; low = c1; s = c2 - c1; end
      else               begin e0 = 0; e1 = 0; low = 0;  s = c1; end
      if (md == 2) e1 = 0;
      ec = (md == 1) ? 2 : 1;
    end else begin
      c1 = q * a;
      if (mv >= c1) begin e0 = 1; low = c1; s = mr - c1; end
      else          begin e0 = 0; low = 0;  s = c1; end
      ec = 1;
    end
    mv = mv - low;
    while (s < 4096) begin
      s  = s * 2;
      mv = ((mv * 2) | int'(sbit(consumed))) & 16383;
      consumed++;
    end
    mr = s;
  endtask

  task automatic step(input bit iv, input bit dv, input logic [19:0] v, output bit fired);
    int avail, e0, e1, ec, md;
    bit acc;
    string tag;
    md = int'(v[19:18]);
    in_valid_i = iv; in_data_i = word_f(fed); dec_valid_i = dv;
    mode_i = v[19:18]; prob_a_i = v[17:12]; prob_b_i = v[11:6]; prob_c_i = v[5:0];
    #1;
    avail = fed * 16 - consumed;
    chk(in_ready_o == (avail <= 16), "R9 in_ready", int'(in_ready_o), int'(avail <= 16));
    chk(dec_ready_o == (init_m && avail >= 12), "R2 dec_ready", int'(dec_ready_o),
        int'(init_m && avail >= 12));
    acc   = iv && in_ready_o;
    fired = dv && dec_ready_o;
    e0 = 0; e1 = 0; ec = 0;
    if (!init_m && avail >= 14) begin
      mv = 0;
      for (int k = 0; k < 14; k++) begin mv = (mv * 2) | int'(sbit(consumed)); consumed++; end
      mr = 16383;
      init_m = 1;
    end else if (fired) begin
      model_dec(md, int'(v[17:12]), int'(v[11:6]), int'(v[5:0]), e0, e1, ec);
    end
    if (acc) fed++;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out_valid_o == fired, "R8 out_valid", int'(out_valid_o), int'(fired));
    if (fired) begin
      if (v[17:12] == 0 || (md == 1 && (v[11:6] == 0 || v[5:0] == 0))) tag = "R4 zero-prob R7";
      else if (md == 1) tag = "R3 pair R7";
      else if (md == 2) tag = "R6 padded R7";
      else tag = "R5 one-bin R7";
      chk(out_cnt_o == 2'(ec), {tag, " count"}, int'(out_cnt_o), ec);
      chk(bin_first_o == 1'(e0), {tag, " first bin"}, int'(bin_first_o), e0);
      chk(bin_second_o == 1'(e1), {tag, " second bin"}, int'(bin_second_o), e1);
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit f;
    int stalled;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(out_valid_o == 1'b0, "R1 out_valid in reset", int'(out_valid_o), 0);
    chk(dec_ready_o == 1'b0, "R1 dec_ready in reset", int'(dec_ready_o), 0);
    chk(in_ready_o == 1'b1, "R1 in_ready in reset", int'(in_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b1, 1'b1, TBL[0], f);
    chk(f == 1'b0, "R1 no decode before offset load", int'(f), 0);

    // table walk with full-rate and throttled feeding
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 16; e++) begin
        f = 0;
        for (int t = 0; t < 40 && !f; t++) step((p % 3 == 0) || (t % 3 != 0), 1'b1, TBL[e], f);
        chk(f == 1'b1, "R2 request eventually taken", int'(f), 1);
      end
    end

    // starve the buffer: ready must drop and requests must be ignored
    stalled = 0;
    for (int t = 0; t < 30; t++) begin
      step(1'b0, 1'b1, TBL[t % 16], f);
      if (!f) stalled++;
    end
    chk(stalled > 0, "R2 stall reached", stalled, 1);
    for (int t = 0; t < 5; t++) step(1'b0, 1'b1, TBL[1], f);
    chk(dec_ready_o == 1'b0, "R2 still stalled", int'(dec_ready_o), 0);

    // resume: state must have survived the stall
    for (int e = 0; e < 16; e++) begin
      f = 0;
      for (int t = 0; t < 40 && !f; t++) step(1'b1, 1'b1, TBL[15 - e], f);
    end
    for (int t = 0; t < 4; t++) step(1'b1, 1'b0, TBL[0], f);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule